// File: doc/BRIEF.md
# Snooping Data Cache Controller

This block is a physically indexed, physically tagged data cache that sits between a load/store unit and a line-oriented memory port. Each CPU request carries its own page policy: copyback, write-through or non-cacheable. Copyback stores stay in the cache and mark their line dirty. Write-through stores update a resident line and also send the word to memory, and they never allocate on a miss. Non-cacheable accesses go straight to the memory port. Loads and copyback stores that miss fetch a whole line. If the victim line is dirty, it is first written back to memory.

A separate snoop input presents the line address of an external bus cycle that is flagged snoopable. Any resident line with that address is invalidated. The snoop owns the tag and data arrays in the cycle it is presented. A CPU step that needs the arrays in that cycle waits one cycle and then sees the result of the invalidation.

The controller is a single state machine with these states:
- `S_IDLE`: takes a request (IDLE→LOOKUP).
- `S_LOOKUP`: compares tags. It stays in LOOKUP on a snoop. Otherwise it moves to RESPOND on a load hit or a copyback store hit, to WRWORD on a write-through store or a non-cacheable store, to NCREAD on a non-cacheable load, to WBACK on a miss with a dirty victim, and to FILL on a miss with a clean victim.
- `S_WBACK`: writes back the dirty victim (WBACK→FILL on acknowledge).
- `S_FILL`: reads the missing line (FILL→INSTALL on acknowledge).
- `S_INSTALL`: writes the line into the arrays. It stays in INSTALL on a snoop and otherwise moves to RESPOND.
- `S_NCREAD`: performs the uncached read (NCREAD→RESPOND on acknowledge).
- `S_WRWORD`: writes a single word to memory (WRWORD→RESPOND on acknowledge).
- `S_RESPOND`: pulses the acknowledge (RESPOND→IDLE).

Top module: `snoop_dcache`

## Requirements
- R1: After reset every line is invalid and `cpu_ack` and `mem_req` are low. The first load to any address therefore misses.
- R2: A load hit returns the addressed 32-bit word with no memory operation. `cpu_ack` pulses for one cycle, two cycles after `cpu_req` is raised. Each set holds four lines with distinct tags at once. The set index is taken from the address bits just above the 16-byte line offset.
- R3: A load miss, or a copyback store miss, issues one line read at the line-aligned address. The line is installed, and the load returns the word taken from the fetched line.
- R4: A copyback store hit updates the word in the cache, issues no memory operation and leaves the line dirty. A later load of that word returns the stored value.
- R5: When a miss replaces a dirty line, one line write carrying the victim's address and current data is issued before the line read for the refill.
- R6: The victim is the lowest-numbered invalid way of the set. If the set has no invalid way, the victim is the way named by that set's round-robin pointer. Each install sets the pointer to the way after the one filled.
- R7: A write-through store hit updates the cached word and issues exactly one word write. The line stays valid and no line operation is issued.
- R8: A write-through store miss issues exactly one word write and allocates nothing. A later load of that line misses.
- R9: Non-cacheable loads read a line and return the addressed word without allocating, so a repeated non-cacheable load reads memory again. Non-cacheable stores issue one word write. Neither touches the arrays.
- R10: A snoop whose line address matches a resident line invalidates that line. A snoop that matches no line has no effect.
- R11: A snoop that arrives while the controller is in LOOKUP or INSTALL is serviced first. The CPU step stalls for that cycle, and the stalled lookup sees the invalidation.
- R12: The encodings are as follows. `cpu_pol` is 0 for copyback, 1 for write-through, and 2 or 3 for non-cacheable. `mem_op` is 0 for a line read, 1 for a line write and 2 for a word write; a word write carries the word in `mem_wdata[31:0]` at the byte address given in `mem_addr`. A memory request holds its op and address until `mem_ack` is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | CPU request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_pol | input | 2 | Page policy of the access |
| cpu_addr | input | ADDR_W | Physical byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ack` |
| mem_req | output | 1 | Memory request |
| mem_op | output | 2 | Memory operation code |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | LINE_BYTES*8 | Line or word write data |
| mem_ack | input | 1 | Memory completion |
| mem_rdata | input | LINE_BYTES*8 | Line read data |
| snp_valid | input | 1 | Snoopable external cycle present |
| snp_line | input | ADDR_W-log2(LINE_BYTES) | Line address of the snooped cycle |

## Verification
A snoop and a CPU tag lookup can fall in the same cycle. The bench provokes this by raising `snp_valid` in the cycle after a request is taken, which is exactly when the controller sits in LOOKUP. When the snoop targets a different set, the hit is judged by its acknowledge arriving one cycle later with correct data and no memory traffic. When the snoop targets the very line being looked up, the request must turn into a miss that reads the line from memory. That outcome shows the snoop was given the arrays first.

// File: rtl/snoop_dcache_pkg.sv
package snoop_dcache_pkg;

    typedef enum logic [1:0] {
        POL_COPYBACK = 2'd0,
        POL_WRTHRU   = 2'd1,
        POL_NOCACHE  = 2'd2
    } pol_e;

    typedef enum logic [1:0] {
        MOP_RD_LINE = 2'd0,
        MOP_WR_LINE = 2'd1,
        MOP_WR_WORD = 2'd2
    } mop_e;

    typedef enum logic [1:0] {
        LS_INVALID = 2'd0,
        LS_VALID   = 2'd1,
        LS_DIRTY   = 2'd3
    } lstate_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOOKUP,
        S_WBACK,
        S_FILL,
        S_INSTALL,
        S_NCREAD,
        S_WRWORD,
        S_RESPOND
    } ctl_state_e;

endpackage

// File: rtl/sdc_tag_store.sv
module sdc_tag_store
    import snoop_dcache_pkg::*;
#(
    parameter int SETS  = 128,
    parameter int WAYS  = 4,
    parameter int TAG_W = 21
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [$clog2(SETS)-1:0]          lk_set,
    input  logic [TAG_W-1:0]                 lk_tag,
    output logic [WAYS-1:0]                  hit_vec,
    output logic [WAYS-1:0]                  valid_vec,
    output logic [WAYS-1:0]                  dirty_vec,
    output logic [WAYS-1:0][TAG_W-1:0]       tags_o,
    output logic [$clog2(WAYS)-1:0]          ptr_o,
    input  logic                             wr_en,
    input  logic [$clog2(SETS)-1:0]          wr_set,
    input  logic [$clog2(WAYS)-1:0]          wr_way,
    input  logic [TAG_W-1:0]                 wr_tag,
    input  lstate_e                          wr_state,
    input  logic                             wr_adv,
    input  logic                             snp_valid,
    input  logic [$clog2(SETS)-1:0]          snp_set,
    input  logic [TAG_W-1:0]                 snp_tag
);
    localparam int WAY_W = $clog2(WAYS);

    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    lstate_e          st_q  [SETS][WAYS];
    logic [WAY_W-1:0] ptr_q [SETS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign valid_vec[w] = (st_q[lk_set][w] != LS_INVALID);
        assign dirty_vec[w] = (st_q[lk_set][w] == LS_DIRTY);
        assign hit_vec[w]   = valid_vec[w] && (tag_q[lk_set][w] == lk_tag);
        assign tags_o[w]    = tag_q[lk_set][w];
    end

    assign ptr_o = ptr_q[lk_set];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                ptr_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    st_q[s][w]  <= LS_INVALID;
                    tag_q[s][w] <= '0;
                end
            end
        end else begin
            if (wr_en) begin
                tag_q[wr_set][wr_way] <= wr_tag;
                st_q[wr_set][wr_way]  <= wr_state;
                if (wr_adv) begin
                    ptr_q[wr_set] <= wr_way + WAY_W'(1);
                end
            end
            // snoop invalidation is applied last so it wins any overlap
            if (snp_valid) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (st_q[snp_set][w] != LS_INVALID && tag_q[snp_set][w] == snp_tag) begin
                        st_q[snp_set][w] <= LS_INVALID;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sdc_data_store.sv
module sdc_data_store #(
    parameter int SETS      = 128,
    parameter int WAYS      = 4,
    parameter int LINE_BITS = 128
) (
    input  logic                               clk,
    input  logic [$clog2(SETS)-1:0]            rd_set,
    output logic [WAYS-1:0][LINE_BITS-1:0]     lines_o,
    input  logic                               wr_en,
    input  logic [$clog2(SETS)-1:0]            wr_set,
    input  logic [$clog2(WAYS)-1:0]            wr_way,
    input  logic [LINE_BITS-1:0]               wr_line
);
    logic [LINE_BITS-1:0] line_q [SETS][WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign lines_o[w] = line_q[rd_set][w];
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[wr_set][wr_way] <= wr_line;
        end
    end

endmodule

// File: rtl/sdc_victim.sv
module sdc_victim #(
    parameter int WAYS = 4
) (
    input  logic [WAYS-1:0]          valid_vec,
    input  logic [$clog2(WAYS)-1:0]  ptr_i,
    output logic [$clog2(WAYS)-1:0]  victim_o
);
    localparam int WAY_W = $clog2(WAYS);

    // scan from the top so the lowest invalid way is the last one kept
    always_comb begin
        victim_o = ptr_i;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) begin
                victim_o = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/snoop_dcache.sv
module snoop_dcache
    import snoop_dcache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int SETS       = 128,
    parameter int WAYS       = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cpu_req,
    input  logic                                   cpu_we,
    input  logic [1:0]                             cpu_pol,
    input  logic [ADDR_W-1:0]                      cpu_addr,
    input  logic [31:0]                            cpu_wdata,
    output logic                                   cpu_ack,
    output logic [31:0]                            cpu_rdata,
    output logic                                   mem_req,
    output logic [1:0]                             mem_op,
    output logic [ADDR_W-1:0]                      mem_addr,
    output logic [LINE_BYTES*8-1:0]                mem_wdata,
    input  logic                                   mem_ack,
    input  logic [LINE_BYTES*8-1:0]                mem_rdata,
    input  logic                                   snp_valid,
    input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   snp_line
);
    localparam int WORD_W    = 32;
    localparam int LINE_BITS = LINE_BYTES * 8;
    localparam int OFF_W     = $clog2(LINE_BYTES);
    localparam int SET_W     = $clog2(SETS);
    localparam int WAY_W     = $clog2(WAYS);
    localparam int TAG_W     = ADDR_W - OFF_W - SET_W;
    localparam int WSEL_W    = OFF_W - 2;

    ctl_state_e st_q, st_d;

    // captured request
    logic              rq_we;
    logic [1:0]        rq_pol;
    logic [ADDR_W-1:0] rq_addr;
    logic [WORD_W-1:0] rq_wdata;

    logic [SET_W-1:0]  rq_set;
    logic [TAG_W-1:0]  rq_tag;
    logic [WSEL_W-1:0] rq_word;
    logic              rq_cb, rq_wt, rq_nc;

    assign rq_set  = rq_addr[OFF_W +: SET_W];
    assign rq_tag  = rq_addr[ADDR_W-1 -: TAG_W];
    assign rq_word = rq_addr[OFF_W-1:2];
    assign rq_cb   = (rq_pol == POL_COPYBACK);
    assign rq_wt   = (rq_pol == POL_WRTHRU);
    assign rq_nc   = !rq_cb && !rq_wt;

    // array interfaces
    logic [WAYS-1:0]                hit_vec, valid_vec, dirty_vec;
    logic [WAYS-1:0][TAG_W-1:0]     set_tags;
    logic [WAY_W-1:0]               rr_ptr, vic_way, hit_way;
    logic [WAYS-1:0][LINE_BITS-1:0] set_lines;
    logic                           hit_any, vic_dirty;

    logic                           tw_en, tw_adv, dw_en;
    logic [WAY_W-1:0]               tw_way, dw_way;
    lstate_e                        tw_state;
    logic [LINE_BITS-1:0]           dw_line;

    // miss bookkeeping
    logic [WAY_W-1:0]     vic_way_q;
    logic [ADDR_W-1:0]    vic_addr_q;
    logic [LINE_BITS-1:0] vic_line_q;
    logic [LINE_BITS-1:0] fill_line_q;
    logic [WORD_W-1:0]    rdata_q;

    function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_BITS-1:0] ln,
                                                    input logic [WSEL_W-1:0] idx);
        return ln[idx*WORD_W +: WORD_W];
    endfunction

    function automatic logic [LINE_BITS-1:0] put_word(input logic [LINE_BITS-1:0] ln,
                                                      input logic [WSEL_W-1:0] idx,
                                                      input logic [WORD_W-1:0] wd);
        logic [LINE_BITS-1:0] r;
        r = ln;
        r[idx*WORD_W +: WORD_W] = wd;
        return r;
    endfunction

    sdc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) tags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_set    (rq_set),
        .lk_tag    (rq_tag),
        .hit_vec   (hit_vec),
        .valid_vec (valid_vec),
        .dirty_vec (dirty_vec),
        .tags_o    (set_tags),
        .ptr_o     (rr_ptr),
        .wr_en     (tw_en),
        .wr_set    (rq_set),
        .wr_way    (tw_way),
        .wr_tag    (rq_tag),
        .wr_state  (tw_state),
        .wr_adv    (tw_adv),
        .snp_valid (snp_valid),
        .snp_set   (snp_line[SET_W-1:0]),
        .snp_tag   (snp_line[SET_W +: TAG_W])
    );

    sdc_data_store #(.SETS(SETS), .WAYS(WAYS), .LINE_BITS(LINE_BITS)) data_i (
        .clk     (clk),
        .rd_set  (rq_set),
        .lines_o (set_lines),
        .wr_en   (dw_en),
        .wr_set  (rq_set),
        .wr_way  (dw_way),
        .wr_line (dw_line)
    );

    sdc_victim #(.WAYS(WAYS)) victim_i (
        .valid_vec (valid_vec),
        .ptr_i     (rr_ptr),
        .victim_o  (vic_way)
    );

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                hit_way = WAY_W'(w);
            end
        end
    end

    assign hit_any   = |hit_vec;
    assign vic_dirty = dirty_vec[vic_way];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (cpu_req) st_d = S_LOOKUP;
            end
            S_LOOKUP: begin
                if (snp_valid) begin
                    st_d = S_LOOKUP;
                end else if (rq_nc) begin
                    st_d = rq_we ? S_WRWORD : S_NCREAD;
                end else if (hit_any) begin
                    st_d = (rq_we && rq_wt) ? S_WRWORD : S_RESPOND;
                end else if (rq_we && rq_wt) begin
                    st_d = S_WRWORD;
                end else begin
                    st_d = vic_dirty ? S_WBACK : S_FILL;
                end
            end
            S_WBACK:   if (mem_ack) st_d = S_FILL;
            S_FILL:    if (mem_ack) st_d = S_INSTALL;
            S_INSTALL: if (!snp_valid) st_d = S_RESPOND;
            S_NCREAD:  if (mem_ack) st_d = S_RESPOND;
            S_WRWORD:  if (mem_ack) st_d = S_RESPOND;
            S_RESPOND: st_d = S_IDLE;
            default:   st_d = S_IDLE;
        endcase
    end

    // outputs and array write controls
    always_comb begin
        cpu_ack   = 1'b0;
        mem_req   = 1'b0;
        mem_op    = MOP_RD_LINE;
        mem_addr  = {rq_tag, rq_set, {OFF_W{1'b0}}};
        mem_wdata = '0;
        tw_en     = 1'b0;
        tw_adv    = 1'b0;
        tw_way    = hit_way;
        tw_state  = LS_VALID;
        dw_en     = 1'b0;
        dw_way    = hit_way;
        dw_line   = put_word(set_lines[hit_way], rq_word, rq_wdata);
        unique case (st_q)
            S_IDLE: ;
            S_LOOKUP: begin
                if (!snp_valid && !rq_nc && hit_any && rq_we) begin
                    dw_en = 1'b1;
                    if (rq_cb) begin
                        tw_en    = 1'b1;
                        tw_state = LS_DIRTY;
                    end
                end
            end
            S_WBACK: begin
                mem_req   = 1'b1;
                mem_op    = MOP_WR_LINE;
                mem_addr  = vic_addr_q;
                mem_wdata = vic_line_q;
            end
            S_FILL, S_NCREAD: begin
                mem_req = 1'b1;
                mem_op  = MOP_RD_LINE;
            end
            S_INSTALL: begin
                if (!snp_valid) begin
                    tw_en    = 1'b1;
                    tw_adv   = 1'b1;
                    tw_way   = vic_way_q;
                    tw_state = rq_we ? LS_DIRTY : LS_VALID;
                    dw_en    = 1'b1;
                    dw_way   = vic_way_q;
                    dw_line  = rq_we ? put_word(fill_line_q, rq_word, rq_wdata) : fill_line_q;
                end
            end
            S_WRWORD: begin
                mem_req   = 1'b1;
                mem_op    = MOP_WR_WORD;
                mem_addr  = rq_addr;
                mem_wdata = {{(LINE_BITS-WORD_W){1'b0}}, rq_wdata};
            end
            S_RESPOND: cpu_ack = 1'b1;
            default: ;
        endcase
    end

    assign cpu_rdata = rdata_q;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_we       <= 1'b0;
            rq_pol      <= '0;
            rq_addr     <= '0;
            rq_wdata    <= '0;
            vic_way_q   <= '0;
            vic_addr_q  <= '0;
            vic_line_q  <= '0;
            fill_line_q <= '0;
            rdata_q     <= '0;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    if (cpu_req) begin
                        rq_we    <= cpu_we;
                        rq_pol   <= cpu_pol;
                        rq_addr  <= cpu_addr;
                        rq_wdata <= cpu_wdata;
                    end
                end
                S_LOOKUP: begin
                    if (!snp_valid) begin
                        rdata_q    <= pick_word(set_lines[hit_way], rq_word);
                        vic_way_q  <= vic_way;
                        vic_addr_q <= {set_tags[vic_way], rq_set, {OFF_W{1'b0}}};
                        vic_line_q <= set_lines[vic_way];
                    end
                end
                S_FILL: begin
                    if (mem_ack) fill_line_q <= mem_rdata;
                end
                S_INSTALL: begin
                    if (!snp_valid) rdata_q <= pick_word(fill_line_q, rq_word);
                end
                S_NCREAD: begin
                    if (mem_ack) rdata_q <= pick_word(mem_rdata, rq_word);
                end
                S_WBACK, S_WRWORD, S_RESPOND: ;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/snoop_dcache_chk.sv
module snoop_dcache_chk
    import snoop_dcache_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ack,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [1:0]        mem_op,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              snp_valid,
    input ctl_state_e        st
);

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_op) && $stable(mem_addr)));

    // R2
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    // R11
    snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (st == S_LOOKUP || st == S_INSTALL)) |=> (st == $past(st)));

    // R5
    wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_op == MOP_WR_LINE) |=> (mem_req && mem_op == MOP_RD_LINE));

    // R7
    word_write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_op == MOP_WR_WORD) |=> cpu_ack);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> (!mem_req && !cpu_ack));

endmodule

bind snoop_dcache snoop_dcache_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ack   (cpu_ack),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_op    (mem_op),
    .mem_addr  (mem_addr),
    .snp_valid (snp_valid),
    .st        (st_q)
);

// File: tb/snoop_dcache_tb_top.sv
`timescale 1ns/1ps
module snoop_dcache_tb_top;
    localparam int ADDR_W = 32;
    localparam int LB     = 16;
    localparam int SETS   = 4;
    localparam int WAYS   = 4;
    localparam int LW     = ADDR_W - 4;

    localparam logic [1:0] CB = 2'd0, WT = 2'd1, NC = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [1:0] cpu_pol = '0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic cpu_ack;
    logic [31:0] cpu_rdata;
    logic mem_req;
    logic [1:0] mem_op;
    logic [31:0] mem_addr;
    logic [127:0] mem_wdata;
    logic mem_ack = 1'b0;
    logic [127:0] mem_rdata = '0;
    logic snp_valid = 1'b0;
    logic [LW-1:0] snp_line = '0;

    always #2.5 clk = ~clk;

    snoop_dcache #(.ADDR_W(ADDR_W), .LINE_BYTES(LB), .SETS(SETS), .WAYS(WAYS)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_pol(cpu_pol), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .snp_valid(snp_valid), .snp_line(snp_line)
    );

    logic [31:0] bmem [4096];
    logic [31:0] gold [4096];
    int n_rd = 0, n_wl = 0, n_ww = 0;
    logic [3:0] hist = '0;
    logic [31:0] last_wl_addr = '0, last_ww_addr = '0, last_ww_data = '0;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    function automatic logic [31:0] ad(input int t, input int s, input int w);
        return 32'((t << 6) | (s << 4) | (w << 2));
    endfunction

    function automatic logic [LW-1:0] ln(input int t, input int s);
        return LW'((t << 2) | s);
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic chk_eq(input string rq, input logic [31:0] act, input logic [31:0] exp);
        chk(act == exp, rq, act, exp);
    endtask

    // memory responder: two-cycle latency, acts at the falling edge
    initial begin
        int wait_c = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                wait_c = 0;
            end else if (mem_req) begin
                wait_c++;
                if (wait_c >= 2) begin
                    int base;
                    base = int'(mem_addr[13:4]) * 4;
                    case (mem_op)
                        2'd0: begin
                            for (int k = 0; k < 4; k++) mem_rdata[k*32 +: 32] = bmem[base + k];
                            n_rd++;
                        end
                        2'd1: begin
                            for (int k = 0; k < 4; k++) bmem[base + k] = mem_wdata[k*32 +: 32];
                            n_wl++;
                            last_wl_addr = mem_addr;
                        end
                        default: begin
                            bmem[int'(mem_addr[13:2])] = mem_wdata[31:0];
                            n_ww++;
                            last_ww_addr = mem_addr;
                            last_ww_data = mem_wdata[31:0];
                        end
                    endcase
                    hist = {hist[1:0], mem_op};
                    mem_ack = 1'b1;
                    wait_c = 0;
                end
            end else begin
                wait_c = 0;
            end
        end
    end

    task automatic access(input logic we, input logic [1:0] pol, input logic [31:0] a,
                          input logic [31:0] wd, input logic snp_en, input logic [LW-1:0] sl,
                          output logic [31:0] rd, output int cyc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_pol = pol; cpu_addr = a; cpu_wdata = wd;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (snp_en && cyc == 1) begin
                snp_valid = 1'b1;
                snp_line = sl;
            end else begin
                snp_valid = 1'b0;
            end
        end while (!cpu_ack);
        rd = cpu_rdata;
        cpu_req = 1'b0;
        snp_valid = 1'b0;
        if (we) gold[int'(a[13:2])] = wd;
    endtask

    task automatic snoop(input logic [LW-1:0] sl);
        @(negedge clk);
        snp_valid = 1'b1;
        snp_line = sl;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    // convenience load with traffic deltas
    logic [31:0] rdv;
    int cyc, d_rd, d_wl, d_ww;

    task automatic op(input logic we, input logic [1:0] pol, input logic [31:0] a,
                      input logic [31:0] wd, input logic snp_en, input logic [LW-1:0] sl);
        int r0, l0, w0;
        r0 = n_rd; l0 = n_wl; w0 = n_ww;
        access(we, pol, a, wd, snp_en, sl, rdv, cyc);
        d_rd = n_rd - r0; d_wl = n_wl - l0; d_ww = n_ww - w0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) begin
            bmem[i] = 32'h5A00_0000 + 32'(i) * 32'h0001_0103;
            gold[i] = bmem[i];
        end
        repeat (3) @(negedge clk);
        chk_eq("R1 reset cpu_ack", 32'(cpu_ack), 32'd0);
        chk_eq("R1 reset mem_req", 32'(mem_req), 32'd0);
        rst_n = 1'b1;

        // R3 fill sweep: tags 1..4 into every set
        for (int s = 0; s < SETS; s++) begin
            for (int t = 1; t <= 4; t++) begin
                op(0, CB, ad(t, s, (t + s) % 4), 0, 0, 0);
                if (s == 0 && t == 1) chk_eq("R1 first load misses", 32'(d_rd), 32'd1);
                chk_eq("R3 miss line read", 32'(d_rd), 32'd1);
                chk_eq("R3 miss no write-back", 32'(d_wl), 32'd0);
                chk_eq("R3 miss data", rdv, gold[int'(ad(t, s, (t + s) % 4)) / 4]);
            end
        end

        // R2 hit sweep over every word of every resident line
        for (int s = 0; s < SETS; s++) begin
            for (int t = 1; t <= 4; t++) begin
                for (int w = 0; w < 4; w++) begin
                    op(0, CB, ad(t, s, w), 0, 0, 0);
                    chk_eq("R2 hit no traffic", 32'(d_rd + d_wl + d_ww), 32'd0);
                    chk_eq("R2 hit latency", 32'(cyc), 32'd2);
                    chk_eq("R2 hit data", rdv, gold[int'(ad(t, s, w)) / 4]);
                end
            end
        end

        // R4 copyback store hit in every set
        for (int s = 0; s < SETS; s++) begin
            op(1, CB, ad(1, s, 2), 32'h1000 + 32'(s), 0, 0);
            chk_eq("R4 store hit no traffic", 32'(d_rd + d_wl + d_ww), 32'd0);
            op(0, CB, ad(1, s, 2), 0, 0, 0);
            chk_eq("R4 reload data", rdv, 32'h1000 + 32'(s));
            chk_eq("R4 reload no traffic", 32'(d_rd), 32'd0);
        end

        // R5 dirty victim written back before refill
        for (int s = 0; s < SETS; s++) begin
            op(0, CB, ad(5, s, 0), 0, 0, 0);
            chk_eq("R5 one write-back", 32'(d_wl), 32'd1);
            chk_eq("R5 one refill", 32'(d_rd), 32'd1);
            chk_eq("R5 victim address", last_wl_addr, ad(1, s, 0));
            chk_eq("R5 order wr-line then rd-line", 32'(hist), 32'b0100);
            chk_eq("R5 written-back data", bmem[int'(ad(1, s, 2)) / 4], 32'h1000 + 32'(s));
            chk_eq("R5 refill data", rdv, gold[int'(ad(5, s, 0)) / 4]);
        end

        // R6 round robin in set 0 (pointer now at way 1)
        op(0, CB, ad(2, 0, 0), 0, 0, 0);
        chk_eq("R6 tag2 still resident", 32'(d_rd), 32'd0);
        op(0, CB, ad(6, 0, 0), 0, 0, 0);
        chk_eq("R6 clean victim no write-back", 32'(d_wl), 32'd0);
        op(0, CB, ad(3, 0, 0), 0, 0, 0);
        chk_eq("R6 tag3 kept", 32'(d_rd), 32'd0);
        op(0, CB, ad(2, 0, 0), 0, 0, 0);
        chk_eq("R6 tag2 evicted by pointer", 32'(d_rd), 32'd1);

        // R6 invalid way preferred, R10 snoop invalidation (set 3)
        snoop(ln(3, 3));
        op(0, CB, ad(7, 3, 0), 0, 0, 0);
        chk_eq("R6 fill into invalid way", 32'(d_rd), 32'd1);
        op(0, CB, ad(2, 3, 1), 0, 0, 0);
        chk_eq("R6 tag2 survives", 32'(d_rd), 32'd0);
        op(0, CB, ad(4, 3, 1), 0, 0, 0);
        chk_eq("R6 tag4 survives", 32'(d_rd), 32'd0);
        op(0, CB, ad(5, 3, 1), 0, 0, 0);
        chk_eq("R6 tag5 survives", 32'(d_rd), 32'd0);
        op(0, CB, ad(3, 3, 1), 0, 0, 0);
        chk_eq("R10 snooped line misses", 32'(d_rd), 32'd1);
        snoop(ln(9, 2));
        op(0, CB, ad(2, 2, 0), 0, 0, 0);
        chk_eq("R10 unmatched snoop no effect", 32'(d_rd), 32'd0);

        // R7 write-through store hit
        op(1, WT, ad(3, 2, 1), 32'hBEEF_0001, 0, 0);
        chk_eq("R7 one word write", 32'(d_ww), 32'd1);
        chk_eq("R7 no line ops", 32'(d_rd + d_wl), 32'd0);
        chk_eq("R12 word write address", last_ww_addr, ad(3, 2, 1));
        chk_eq("R12 word write data", last_ww_data, 32'hBEEF_0001);
        op(0, CB, ad(3, 2, 1), 0, 0, 0);
        chk_eq("R7 line still valid", 32'(d_rd), 32'd0);
        chk_eq("R7 cached word updated", rdv, 32'hBEEF_0001);

        // R8 write-through store miss
        op(1, WT, ad(10, 1, 0), 32'hCAFE_0010, 0, 0);
        chk_eq("R8 one word write", 32'(d_ww), 32'd1);
        chk_eq("R8 no line read", 32'(d_rd), 32'd0);
        op(0, CB, ad(10, 1, 0), 0, 0, 0);
        chk_eq("R8 not allocated", 32'(d_rd), 32'd1);
        chk_eq("R8 memory data", rdv, 32'hCAFE_0010);

        // R9 non-cacheable
        op(0, NC, ad(11, 0, 3), 0, 0, 0);
        chk_eq("R9 nc load reads", 32'(d_rd), 32'd1);
        chk_eq("R9 nc load data", rdv, gold[int'(ad(11, 0, 3)) / 4]);
        op(0, NC, ad(11, 0, 3), 0, 0, 0);
        chk_eq("R9 nc load not allocated", 32'(d_rd), 32'd1);
        op(1, 2'd3, ad(11, 0, 1), 32'h0DD0_0003, 0, 0);
        chk_eq("R9 nc store word write", 32'(d_ww), 32'd1);
        chk_eq("R9 nc store no line op", 32'(d_rd + d_wl), 32'd0);
        op(0, CB, ad(11, 0, 1), 0, 0, 0);
        chk_eq("R9 arrays untouched", 32'(d_rd), 32'd1);
        chk_eq("R9 data from memory", rdv, 32'h0DD0_0003);

        // R11 snoop collides with lookup
        op(0, CB, ad(2, 2, 3), 0, 1, ln(9, 1));
        chk_eq("R11 stall one cycle", 32'(cyc), 32'd3);
        chk_eq("R11 still a hit", 32'(d_rd), 32'd0);
        chk_eq("R11 hit data", rdv, gold[int'(ad(2, 2, 3)) / 4]);
        op(0, CB, ad(4, 2, 2), 0, 1, ln(4, 2));
        chk_eq("R11 snoop first makes miss", 32'(d_rd), 32'd1);
        chk_eq("R11 miss data", rdv, gold[int'(ad(4, 2, 2)) / 4]);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule